// File: doc/BRIEF.md
# Tag correlation prefetch predictor

This block sits beside a level-one data cache and watches the addresses of its misses. For every cache set it keeps a short history of the block tags that missed there. A set-associative pattern table learns, for each tag history, which tag came next in that set. When a miss arrives, the block first trains the pattern table with the history it held before the miss. It then appends the miss tag to that history. Finally it looks the new history up to predict the next block in the same set. A confident prediction leaves as a one-cycle prefetch request aimed at the second-level cache.

The pattern table set is chosen by summing the tags of the history and keeping the low bits of the sum. Within that set, the way whose stored key equals the newest tag of the history is selected. Misses are taken one at a time: the accept handshake stays closed while training and prediction run. All table sizes, the address split and the history length are parameters.

Top module: `tcp_predictor`

## Requirements
- R1: A miss address splits, from the top down, into a tag of ADDR_W-SET_W-OFF_W bits, a set field of SET_W bits and a byte offset of OFF_W bits. The offset never affects any result.
- R2: After reset every history entry reads as K zero tags and every pattern way is empty. miss_ready is 1 and pf_valid is 0.
- R3: The pattern set index is the sum, modulo 2^IDX_W, of the low IDX_W bits of each of the K tags in a history.
- R4: Training uses the history held before the miss. If a valid way in the indexed set has a key equal to the newest tag of that history, its successor field takes the miss tag.
- R5: If no valid way matches during training, a way is filled with key = newest history tag and successor = miss tag. The way is chosen by a per-set round-robin pointer that starts at way 0 and advances by one, modulo WAYS, on each fill.
- R6: After training, the history of the miss set drops its oldest tag and takes the miss tag as its newest.
- R7: Prediction indexes the pattern table with the new history and selects the valid way whose key equals the miss tag. On a hit, pf_addr = {successor tag, miss set, OFF_W zero bits}.
- R8: If no valid way matches during prediction, pf_valid stays 0 for that miss.
- R9: A miss is taken on a clock edge where miss_valid and miss_ready are both 1. miss_ready is then 0 for the next two cycles. Any pf_valid pulse lasts one cycle and comes in the cycle in which miss_ready is again 1.
- R10: The history length K = 1 works: the history is then just the previous miss tag of the set, and the index is that tag's low IDX_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss address is offered |
| miss_ready | output | 1 | The block can take a miss this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| pf_valid | output | 1 | One-cycle prefetch request |
| pf_addr | output | ADDR_W | Block-aligned prefetch address |

## Verification
A miss taken at edge E0 is trained at E1 and predicted at E2. The bench therefore samples at the falling edge after each of these three edges. After E0 and after E1 it expects miss_ready low and no prefetch. After E2 it expects miss_ready high and the predicted pf_valid and pf_addr. The predictions come from a model of both tables that the bench updates arithmetically for each miss. It drives two instances, with history lengths 2 and 1, in lockstep. The stimulus includes a scaled copy of the four-tag worked sequence, offset sweeps, fills that wrap the round-robin pointer, and a long pseudo-random run over a small tag space.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_TRAIN  = 2'd1,
      ST_LOOKUP = 2'd2
   } tcp_state_e;
endpackage

// File: rtl/tcp_index_hash.sv
module tcp_index_hash #(
   parameter int TAG_W = 17,
   parameter int K     = 2,
   parameter int IDX_W = 8
) (
   input  logic [K*TAG_W-1:0] seq,
   output logic [IDX_W-1:0]   idx
);
   generate
      if (TAG_W < IDX_W) begin : g_bad_width
         $error("tcp_index_hash: TAG_W must be at least IDX_W");
      end
      if (K == 1) begin : g_single
         assign idx = seq[IDX_W-1:0];
      end else begin : g_sum
         always_comb begin
            idx = '0;
            for (int j = 0; j < K; j++) begin
               idx = idx + seq[j*TAG_W +: IDX_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tcp_hist_table.sv
module tcp_hist_table #(
   parameter int SET_W = 10,
   parameter int TAG_W = 17,
   parameter int K     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SET_W-1:0]   rd_set,
   output logic [K*TAG_W-1:0] rd_seq,
   input  logic               wr_en,
   input  logic [SET_W-1:0]   wr_set,
   input  logic [K*TAG_W-1:0] wr_seq
);
   localparam int SETS = 1 << SET_W;

   logic [SETS-1:0]    vld_q;
   logic [K*TAG_W-1:0] seq_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_set] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         seq_q[wr_set] <= wr_seq;
      end
   end

   assign rd_seq = vld_q[rd_set] ? seq_q[rd_set] : '0;
endmodule

// File: rtl/tcp_pattern_table.sv
module tcp_pattern_table #(
   parameter int IDX_W = 8,
   parameter int WAYS  = 8,
   parameter int TAG_W = 17,
   parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] srch_idx,
   input  logic [TAG_W-1:0] srch_key,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way,
   output logic [TAG_W-1:0] hit_next,
   output logic [WAY_W-1:0] victim_way,
   input  logic             wr_en,
   input  logic             wr_alloc,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [TAG_W-1:0] wr_key,
   input  logic [TAG_W-1:0] wr_next
);
   localparam int SETS = 1 << IDX_W;
   localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

   logic [WAYS-1:0]  vld_q   [SETS];
   logic [WAY_W-1:0] rr_q    [SETS];
   logic [TAG_W-1:0] key_q   [SETS][WAYS];
   logic [TAG_W-1:0] next_q  [SETS][WAYS];

   generate
      if (WAYS < 1) begin : g_bad_ways
         $error("tcp_pattern_table: WAYS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) begin
            vld_q[i] <= '0;
            rr_q[i]  <= '0;
         end
      end else if (wr_en) begin
         vld_q[wr_idx][wr_way] <= 1'b1;
         if (wr_alloc) begin
            rr_q[wr_idx] <= (rr_q[wr_idx] == LAST_WAY) ? '0 : rr_q[wr_idx] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         key_q[wr_idx][wr_way]  <= wr_key;
         next_q[wr_idx][wr_way] <= wr_next;
      end
   end

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (vld_q[srch_idx][w] && (key_q[srch_idx][w] == srch_key)) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   assign hit_next   = next_q[srch_idx][hit_way];
   assign victim_way = rr_q[srch_idx];
endmodule

// File: rtl/tcp_predictor.sv
module tcp_predictor #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6,
   parameter int SET_W  = 10,
   parameter int IDX_W  = 8,
   parameter int WAYS   = 8,
   parameter int K      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   output logic              miss_ready,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr
);
   import tcp_pkg::*;

   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam int TAG_LO = SET_W + OFF_W;
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam logic [ADDR_W-1:0] ALIGN = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

   generate
      if (TAG_W < 1) begin : g_bad_split
         $error("tcp_predictor: address too narrow for set and offset");
      end
      if (K < 1) begin : g_bad_k
         $error("tcp_predictor: K must be at least 1");
      end
   endgenerate

   tcp_state_e        state_q;
   logic [ADDR_W-1:0] blk_q;
   logic [TAG_W-1:0]  miss_tag;
   logic [SET_W-1:0]  miss_set;

   logic [K*TAG_W-1:0] hist_seq;
   logic [K*TAG_W-1:0] hist_next;
   logic [TAG_W-1:0]   hist_newest;
   logic [IDX_W-1:0]   pht_idx;
   logic [TAG_W-1:0]   pht_key;
   logic               pht_hit;
   logic [WAY_W-1:0]   pht_hit_way;
   logic [TAG_W-1:0]   pht_next;
   logic [WAY_W-1:0]   pht_victim;
   logic               train;

   assign miss_tag    = blk_q[ADDR_W-1:TAG_LO];
   assign miss_set    = blk_q[TAG_LO-1:OFF_W];
   assign hist_newest = hist_seq[(K-1)*TAG_W +: TAG_W];
   assign train       = (state_q == ST_TRAIN);
   assign miss_ready  = (state_q == ST_IDLE);

   generate
      if (K == 1) begin : g_shift1
         assign hist_next = miss_tag;
      end else begin : g_shiftk
         assign hist_next = {miss_tag, hist_seq[K*TAG_W-1:TAG_W]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         blk_q    <= '0;
         pf_valid <= 1'b0;
         pf_addr  <= '0;
      end else begin
         pf_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (miss_valid) begin
                  blk_q   <= miss_addr & ALIGN;
                  state_q <= ST_TRAIN;
               end
            end
            ST_TRAIN: begin
               state_q <= ST_LOOKUP;
            end
            ST_LOOKUP: begin
               pf_valid <= pht_hit;
               if (pht_hit) begin
                  pf_addr <= {pht_next, blk_q[TAG_LO-1:0]};
               end
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   tcp_hist_table #(.SET_W(SET_W), .TAG_W(TAG_W), .K(K)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_set (miss_set),
      .rd_seq (hist_seq),
      .wr_en  (train),
      .wr_set (miss_set),
      .wr_seq (hist_next)
   );

   tcp_index_hash #(.TAG_W(TAG_W), .K(K), .IDX_W(IDX_W)) u_hash (
      .seq (hist_seq),
      .idx (pht_idx)
   );

   assign pht_key = train ? hist_newest : miss_tag;

   tcp_pattern_table #(.IDX_W(IDX_W), .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_pattern (
      .clk        (clk),
      .rst_n      (rst_n),
      .srch_idx   (pht_idx),
      .srch_key   (pht_key),
      .hit        (pht_hit),
      .hit_way    (pht_hit_way),
      .hit_next   (pht_next),
      .victim_way (pht_victim),
      .wr_en      (train),
      .wr_alloc   (!pht_hit),
      .wr_idx     (pht_idx),
      .wr_way     (pht_hit ? pht_hit_way : pht_victim),
      .wr_key     (hist_newest),
      .wr_next    (miss_tag)
   );
endmodule

// File: rtl/tcp_predictor_chk.sv
module tcp_predictor_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6,
   parameter int SET_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_valid,
   input logic              miss_ready,
   input logic [ADDR_W-1:0] miss_addr,
   input logic              pf_valid,
   input logic [ADDR_W-1:0] pf_addr
);
   logic [SET_W-1:0] cap_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_set <= '0;
      else if (miss_valid && miss_ready) cap_set <= miss_addr[SET_W+OFF_W-1:OFF_W];
   end

   AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !miss_ready); // R9
   AST_PF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |=> !pf_valid); // R9
   AST_PF_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> miss_ready); // R9
   AST_PF_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> $past(!miss_ready)); // R9
   AST_PF_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> (pf_addr[OFF_W-1:0] == '0)); // R7
   AST_PF_SAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> (pf_addr[SET_W+OFF_W-1:OFF_W] == cap_set)); // R1
endmodule

bind tcp_predictor tcp_predictor_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .miss_valid (miss_valid),
   .miss_ready (miss_ready),
   .miss_addr  (miss_addr),
   .pf_valid   (pf_valid),
   .pf_addr    (pf_addr)
);

// File: tb/tb_tcp_predictor.sv
module tb_tcp_predictor;
   localparam int AW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic miss_valid = 1'b0;
   logic [AW-1:0] miss_addr = '0;
   logic rdy2, rdy1, pf2, pf1;
   logic [AW-1:0] pa2, pa1;

   int nvec = 0;
   int nerr = 0;

   always #2.5 clk = ~clk;

   tcp_predictor #(.ADDR_W(AW), .OFF_W(2), .SET_W(2), .IDX_W(2), .WAYS(2), .K(2)) dut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(rdy2),
      .miss_addr(miss_addr), .pf_valid(pf2), .pf_addr(pa2));

   tcp_predictor #(.ADDR_W(AW), .OFF_W(2), .SET_W(2), .IDX_W(2), .WAYS(2), .K(1)) dut_k1 (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(rdy1),
      .miss_addr(miss_addr), .pf_valid(pf1), .pf_addr(pa1));

   // bench model: c = 0 for history length 2, c = 1 for history length 1
   logic [7:0] m_tht [2][4][2];
   bit         m_thtv [2][4];
   bit         m_v [2][4][2];
   logic [7:0] m_key [2][4][2];
   logic [7:0] m_nxt [2][4][2];
   int         m_rr [2][4];

   task automatic chk(input bit ok, input string lbl, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
      end
   endtask

   task automatic model(input int c, input int kk, input logic [AW-1:0] a,
                        output bit pf, output logic [AW-1:0] pa);
      logic [7:0] tg;
      int s, idx, w;
      logic [7:0] h [2];
      tg = a[11:4];
      s  = int'(a[3:2]);
      for (int j = 0; j < kk; j++) h[j] = m_thtv[c][s] ? m_tht[c][s][j] : 8'h00;
      idx = 0;
      for (int j = 0; j < kk; j++) idx = (idx + int'(h[j][1:0])) % 4;
      w = -1;
      for (int x = 1; x >= 0; x--) if (m_v[c][idx][x] && m_key[c][idx][x] == h[kk-1]) w = x;
      if (w >= 0) begin
         m_nxt[c][idx][w] = tg;
      end else begin
         w = m_rr[c][idx];
         m_v[c][idx][w] = 1'b1;
         m_key[c][idx][w] = h[kk-1];
         m_nxt[c][idx][w] = tg;
         m_rr[c][idx] = (m_rr[c][idx] + 1) % 2;
      end
      for (int j = 0; j < kk - 1; j++) m_tht[c][s][j] = h[j+1];
      m_tht[c][s][kk-1] = tg;
      m_thtv[c][s] = 1'b1;
      idx = 0;
      for (int j = 0; j < kk; j++) idx = (idx + int'(m_tht[c][s][j][1:0])) % 4;
      pf = 1'b0;
      pa = '0;
      for (int x = 1; x >= 0; x--) begin
         if (m_v[c][idx][x] && m_key[c][idx][x] == tg) begin
            pf = 1'b1;
            pa = {m_nxt[c][idx][x], a[3:2], 2'b00};
         end
      end
   endtask

   task automatic send(input logic [AW-1:0] a, input string lbl);
      bit e2, e1;
      logic [AW-1:0] p2, p1;
      model(0, 2, a, e2, p2);
      model(1, 1, a, e1, p1);
      miss_valid = 1'b1;
      miss_addr  = a;
      @(posedge clk);
      @(negedge clk);
      miss_valid = 1'b0;
      chk(!rdy2 && !rdy1, "R9 busy after take", {rdy2, rdy1}, 0);
      @(posedge clk);
      @(negedge clk);
      chk(!rdy2 && !rdy1 && !pf2 && !pf1, "R9 busy, no early prefetch", {rdy2, rdy1, pf2, pf1}, 0);
      @(posedge clk);
      @(negedge clk);
      chk(rdy2 && rdy1, "R9 ready returns", {rdy2, rdy1}, 3);
      chk(pf2 == e2, e2 ? {lbl, " R7 hit"} : {lbl, " R8 no prefetch"}, pf2, e2);
      if (e2 && pf2) chk(pa2 == p2, {lbl, " R7 address"}, pa2, p2);
      chk(pf1 == e1, e1 ? {lbl, " R10 R7 hit"} : {lbl, " R10 R8 no prefetch"}, pf1, e1);
      if (e1 && pf1) chk(pa1 == p1, {lbl, " R10 R7 address"}, pa1, p1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      for (int c = 0; c < 2; c++)
         for (int s = 0; s < 4; s++) begin
            m_thtv[c][s] = 1'b0;
            m_rr[c][s] = 0;
            for (int w = 0; w < 2; w++) m_v[c][s][w] = 1'b0;
         end
      repeat (3) @(negedge clk);
      chk(rdy2 && rdy1 && !pf2 && !pf1, "R2 reset state", {rdy2, rdy1, pf2, pf1}, 4'hC);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rdy2 && rdy1 && !pf2 && !pf1, "R2 after reset release", {rdy2, rdy1, pf2, pf1}, 4'hC);

      // scaled worked sequence in set 3, repeated so later passes predict
      for (int p = 0; p < 3; p++) begin
         send({8'h11, 2'd3, 2'd0}, "R3 R4 R6");
         send({8'h22, 2'd3, 2'd0}, "R3 R4 R6");
         send({8'h33, 2'd3, 2'd0}, "R3 R4 R6");
         send({8'h44, 2'd3, 2'd0}, "R3 R4 R6");
      end

      // offsets must not matter
      for (int p = 0; p < 4; p++) begin
         send({8'h05, 2'd1, 2'(p)}, "R1 offset");
         send({8'h06, 2'd1, 2'(3 - p)}, "R1 offset");
      end

      // many distinct tags in set 2 wrap the round-robin fill pointer
      for (int p = 0; p < 2; p++)
         for (int t = 0; t < 10; t++) send({8'(8'h40 + t * 4), 2'd2, 2'd1}, "R5 fill");

      // pseudo-random misses over a small tag space
      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send({6'b0, lfsr[1:0], lfsr[5:4], lfsr[9:8]}, "R3 R4 R5 R6 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule